// File: doc/BRIEF.md
# Timer Tick Generator with Grouped Prescalers

This block turns one system clock into count-enable ticks for five PWM timer channels. The channels are split into two groups, and each group has its own 8-bit prescaler. A prescaler wraps once every (value + 1) system cycles. Each channel then divides its group's wrap rate by 2, 4, 8 or 16. A channel can instead take its ticks from its group's external clock input, which the block synchronizes and edge-detects. A build option adds a divide-by-1 setting. Every tick is a registered pulse that lasts one system clock cycle.

Software programs the block through two registers on a simple write and read port. The configuration register holds both prescaler values. The select register holds one 4-bit field per channel, and that one code sets both the tick source and the division. A new value is written into a visible holding register and takes effect only when the owning group's prescaler next wraps. A channel therefore never emits a shortened period when it is reconfigured.

Top module: `tmr_tick_gen`

## Requirements
- R1: After reset, both registers read zero, every tick output stays low during reset and during the first cycle after reset, and the defaults (prescale 0, code 0) give every channel one tick every 2 cycles.
- R2: Address 0 reads back the prescaler register: group 0 value in bits 7:0 and group 1 value in bits 15:8. Address 1 reads back the select register: channel c's code in bits 4c+3:4c. Codes are stored as written, even when they are reserved. All unused bits read as zero.
- R3: Group 0 (prescaler value P0) serves channels 0 and 1. Group 1 (value P1) serves channels 2, 3 and 4. A group's prescaler wraps every P+1 system cycles.
- R4: Select codes 0, 1, 2 and 3 give one tick every 2, 4, 8 and 16 wraps of the channel's group prescaler, and ticks occur only on those wraps.
- R5: Select code 4 makes the channel tick once for each rising edge of its group's external clock input (input 0 for channels 0 and 1, input 1 for channels 2 to 4). The edge passes through a two-flop synchronizer first.
- R6: A new prescaler value or select code takes effect at the next wrap of the owning group's prescaler. For example, when prescale 49 with code 0 is changed to prescale 0 just after a tick, the next tick comes exactly 51 cycles after that tick.
- R7: When the divide-by-1 build option is on, code 5 makes the channel tick on every wrap of its group prescaler.
- R8: Codes 6 to 15, and code 5 when the divide-by-1 option is off, silence the channel: it emits no ticks.
- R9: Whenever a channel's tick period is longer than one cycle, each tick is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 prescaler register, 1 select register |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read target: 0 prescaler register, 1 select register |
| rd_data | output | 32 | Combinational read data |
| ext_clk | input | 2 | Asynchronous external clocks, one per group |
| tick | output | 5 | Per-channel count-enable pulses |

## Verification
The bench measures steady tick intervals on every channel for a range of prescaler and code settings. Some channels in a group are given different divisors, so a design that wires a channel to the wrong group, or offsets the divide-by-N+1 count, shows a wrong interval. A reconfiguration made in the middle of a period must produce the exact 51-cycle bridge interval; a design that applies writes at once would tick far sooner. Reserved codes must keep a channel silent while the readback still shows the written code. The divide-by-1 variant must tick every cycle, and an external-clock channel must tick at the external rate without being disturbed by prescaler wraps.

// File: rtl/tmr_tick_pkg.sv
// Shared constants and helpers for the timer tick generator.
// Assumes two channel groups and 4-bit per-channel select codes.
package tmr_tick_pkg;
    localparam int SEL_W = 4;
    localparam int NUM_GRP = 2;

    localparam logic [SEL_W-1:0] SEL_DIV2 = 4'd0;
    localparam logic [SEL_W-1:0] SEL_DIV4 = 4'd1;
    localparam logic [SEL_W-1:0] SEL_DIV8 = 4'd2;
    localparam logic [SEL_W-1:0] SEL_DIV16 = 4'd3;
    localparam logic [SEL_W-1:0] SEL_EXT = 4'd4;
    localparam logic [SEL_W-1:0] SEL_DIV1 = 4'd5;

    // Group that a channel belongs to, given the size of group 0.
    function automatic int grp_of(input int ch, input int grp0_ch);
        return (ch < grp0_ch) ? 0 : 1;
    endfunction
endpackage

// File: rtl/tmr_regs.sv
// Holding registers for the prescaler and select words, with readback.
// Assumes DATA_W covers both 2*PRE_W and NUM_CH*SEL_W bits.
module tmr_regs
    import tmr_tick_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int PRE_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic                            wr_addr,
    input  logic [DATA_W-1:0]               wr_data,
    input  logic                            rd_addr,
    output logic [DATA_W-1:0]               rd_data,
    output logic [NUM_GRP-1:0][PRE_W-1:0]   pre_hold,
    output logic [NUM_CH-1:0][SEL_W-1:0]    sel_hold
);
    localparam int PRE_BITS = NUM_GRP * PRE_W;
    localparam int SEL_BITS = NUM_CH * SEL_W;

    logic [PRE_BITS-1:0] pre_reg;
    logic [SEL_BITS-1:0] sel_reg;

    // Capture writes into the addressed holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_reg <= '0;
            sel_reg <= '0;
        end else if (wr_en) begin
            if (!wr_addr) pre_reg <= wr_data[PRE_BITS-1:0];
            else          sel_reg <= wr_data[SEL_BITS-1:0];
        end
    end

    // Return the addressed register, zero-filled above its fields.
    always_comb begin
        rd_data = '0;
        if (!rd_addr) rd_data[PRE_BITS-1:0] = pre_reg;
        else          rd_data[SEL_BITS-1:0] = sel_reg;
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_pre
        assign pre_hold[g] = pre_reg[g*PRE_W +: PRE_W];
    end
    for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
        assign sel_hold[c] = sel_reg[c*SEL_W +: SEL_W];
    end
endmodule

// File: rtl/tmr_prescaler.sv
// Group prescaler: wraps every (active value + 1) cycles and loads the held
// value at each wrap. Assumes the held value may change at any time.
module tmr_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] hold_val,
    output logic             wrap,
    output logic [PRE_W-1:0] cnt,
    output logic [PRE_W-1:0] act_val
);
    assign wrap = (cnt == act_val);

    // Count up to the active value, then restart and adopt the held value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            act_val <= '0;
        end else if (wrap) begin
            cnt     <= '0;
            act_val <= hold_val;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_ext_sync.sv
// Two-flop synchronizer plus rising-edge detector for one external clock.
// Assumes the external clock is slower than half the system clock.
module tmr_ext_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    output logic rise
);
    logic [2:0] sh;

    // Shift the asynchronous input through the synchronizer and history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[1:0], ext_in};
    end

    assign rise = sh[1] & ~sh[2];
endmodule

// File: rtl/tmr_chan_div.sv
// Per-channel source select and power-of-two divider. The select code is
// adopted at the group wrap; a changed code restarts the divide count.
module tmr_chan_div
    import tmr_tick_pkg::*;
#(
    parameter bit HAS_DIV1 = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre_wrap,
    input  logic             ext_rise,
    input  logic [SEL_W-1:0] sel_hold,
    output logic [SEL_W-1:0] act_sel,
    output logic             tick
);
    logic [3:0] dcnt;
    logic [3:0] mask;
    logic       tick_nxt;

    // Decode which divide-count bits must all be set for a tick.
    always_comb begin
        case (act_sel)
            SEL_DIV2:  mask = 4'b0001;
            SEL_DIV4:  mask = 4'b0011;
            SEL_DIV8:  mask = 4'b0111;
            SEL_DIV16: mask = 4'b1111;
            default:   mask = 4'b0000;
        endcase
    end

    // Pick the tick source for the active code; reserved codes stay silent.
    always_comb begin
        case (act_sel)
            SEL_DIV2, SEL_DIV4, SEL_DIV8, SEL_DIV16:
                tick_nxt = pre_wrap && ((dcnt & mask) == mask);
            SEL_EXT:  tick_nxt = ext_rise;
            SEL_DIV1: tick_nxt = HAS_DIV1 && pre_wrap;
            default:  tick_nxt = 1'b0;
        endcase
    end

    // Register the tick and advance or reload the divider at each group wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_sel <= '0;
            dcnt    <= '0;
            tick    <= 1'b0;
        end else begin
            tick <= tick_nxt;
            if (pre_wrap) begin
                if (sel_hold != act_sel) begin
                    act_sel <= sel_hold;
                    dcnt    <= '0;
                end else begin
                    dcnt <= dcnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tmr_tick_gen.sv
// Timer tick generator top: two group prescalers, two external clock
// synchronizers and one divider/select stage per channel.
// Assumes a single clock domain apart from the ext_clk inputs.
module tmr_tick_gen
    import tmr_tick_pkg::*;
#(
    parameter int NUM_CH   = 5,
    parameter int GRP0_CH  = 2,
    parameter int PRE_W    = 8,
    parameter int DATA_W   = 32,
    parameter bit HAS_DIV1 = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [1:0]        ext_clk,
    output logic [NUM_CH-1:0] tick
);
    logic [NUM_GRP-1:0][PRE_W-1:0] pre_hold;
    logic [NUM_GRP-1:0][PRE_W-1:0] pre_cnt;
    logic [NUM_GRP-1:0][PRE_W-1:0] pre_act;
    logic [NUM_GRP-1:0]            pre_wrap;
    logic [NUM_GRP-1:0]            ext_edge;
    logic [NUM_CH-1:0][SEL_W-1:0]  sel_hold;
    logic [NUM_CH-1:0][SEL_W-1:0]  ch_sel;

    tmr_regs #(.NUM_CH(NUM_CH), .PRE_W(PRE_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pre_hold(pre_hold), .sel_hold(sel_hold)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
            .clk(clk), .rst_n(rst_n), .hold_val(pre_hold[g]),
            .wrap(pre_wrap[g]), .cnt(pre_cnt[g]), .act_val(pre_act[g])
        );
        tmr_ext_sync u_sync (
            .clk(clk), .rst_n(rst_n), .ext_in(ext_clk[g]), .rise(ext_edge[g])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int G = grp_of(c, GRP0_CH);
        tmr_chan_div #(.HAS_DIV1(HAS_DIV1)) u_div (
            .clk(clk), .rst_n(rst_n), .pre_wrap(pre_wrap[G]),
            .ext_rise(ext_edge[G]), .sel_hold(sel_hold[c]),
            .act_sel(ch_sel[c]), .tick(tick[c])
        );
    end
endmodule

// File: rtl/tmr_tick_gen_chk.sv
// Property checker for the timer tick generator, bound to every instance.
// Assumes the top's internal group and channel state nets are visible.
module tmr_tick_gen_chk
    import tmr_tick_pkg::*;
#(
    parameter int NUM_CH   = 5,
    parameter int GRP0_CH  = 2,
    parameter int PRE_W    = 8,
    parameter int DATA_W   = 32,
    parameter bit HAS_DIV1 = 1'b0
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          rd_addr,
    input logic [DATA_W-1:0]             rd_data,
    input logic [NUM_CH-1:0]             tick,
    input logic [NUM_GRP-1:0]            pre_wrap,
    input logic [NUM_GRP-1:0]            ext_edge,
    input logic [NUM_GRP-1:0][PRE_W-1:0] pre_cnt,
    input logic [NUM_GRP-1:0][PRE_W-1:0] pre_act,
    input logic [NUM_CH-1:0][SEL_W-1:0]  ch_sel
);
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (tick == '0));

    a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_addr |-> (rd_data[DATA_W-1:NUM_GRP*PRE_W] == '0));

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
            pre_cnt[g] <= pre_act[g]);
        a_r6_pre_held: assert property (@(posedge clk) disable iff (!rst_n)
            !pre_wrap[g] |=> $stable(pre_act[g]));
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int G = grp_of(c, GRP0_CH);
        a_r4_tick_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_sel[c] < SEL_EXT && !pre_wrap[G]) |=> !tick[c]);
        a_r5_ext_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_sel[c] == SEL_EXT && !ext_edge[G]) |=> !tick[c]);
        a_r8_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_sel[c] > SEL_DIV1 || (ch_sel[c] == SEL_DIV1 && !HAS_DIV1))
            |=> !tick[c]);
    end
endmodule

bind tmr_tick_gen tmr_tick_gen_chk #(
    .NUM_CH(NUM_CH), .GRP0_CH(GRP0_CH), .PRE_W(PRE_W),
    .DATA_W(DATA_W), .HAS_DIV1(HAS_DIV1)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .tick(tick), .pre_wrap(pre_wrap), .ext_edge(ext_edge),
    .pre_cnt(pre_cnt), .pre_act(pre_act), .ch_sel(ch_sel)
);

// File: tb/tmr_tick_gen_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected tick periods and the monitor
// measures steady intervals on the DUT outputs and compares them.
module tmr_tick_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_addr = 1'b0;
    logic [31:0] rd_data, rd_data1;
    logic        ext0 = 1'b0, ext1 = 1'b0;
    logic [4:0]  tick0, tick1;
    int          cyc = 0;
    int          checks = 0, fails = 0;
    bit          done = 1'b0;

    typedef struct { int ch; int per; int dut; string req; } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tmr_tick_gen u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ext_clk({ext1, ext0}), .tick(tick0)
    );
    tmr_tick_gen #(.HAS_DIV1(1'b1)) u_dut1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data1),
        .ext_clk({ext1, ext0}), .tick(tick1)
    );

    // External clocks: period 12 cycles on input 0, 16 cycles on input 1.
    initial forever begin repeat (6) @(negedge clk); ext0 = ~ext0; end
    initial forever begin repeat (8) @(negedge clk); ext1 = ~ext1; end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit tk(input int dut, input int ch);
        return dut != 0 ? tick1[ch] : tick0[ch];
    endfunction

    task automatic wait_tick(input int dut, input int ch, output int t);
        do @(negedge clk); while (!tk(dut, ch));
        t = cyc;
    endtask

    // Monitor: discard settling ticks, then compare two steady intervals.
    initial forever begin
        exp_t e;
        int t0, t1, t2, dummy;
        wait (exp_q.size() > 0);
        e = exp_q[0];
        for (int i = 0; i < 3; i++) wait_tick(e.dut, e.ch, dummy);
        wait_tick(e.dut, e.ch, t0);
        if (e.per > 1) begin
            @(negedge clk);
            check(!tk(e.dut, e.ch), "R9 single-cycle pulse", 1, 0);
        end
        wait_tick(e.dut, e.ch, t1);
        wait_tick(e.dut, e.ch, t2);
        check(t1 - t0 == e.per, e.req, t1 - t0, e.per);
        check(t2 - t1 == e.per, e.req, t2 - t1, e.per);
        void'(exp_q.pop_front());
    end

    task automatic expect_per(input int dut, input int ch, input int per, input string req);
        exp_t e;
        e.ch = ch; e.per = per; e.dut = dut; e.req = req;
        exp_q.push_back(e);
        wait (exp_q.size() == 0);
    endtask

    task automatic wr(input bit addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input bit addr, input logic [31:0] exp, input string req);
        @(negedge clk);
        rd_addr = addr;
        #1;
        check(rd_data == exp, req, int'(rd_data), int'(exp));
    endtask

    task automatic count_silent(input int dut, input int ch, input string req);
        int n = 0;
        repeat (200) begin @(negedge clk); if (tk(dut, ch)) n++; end
        check(n == 0, req, n, 0);
    endtask

    initial begin
        int t0, t1;
        repeat (4) begin
            @(negedge clk);
            check(tick0 == 0, "R1 ticks low in reset", int'(tick0), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check(tick0 == 0 && tick1 == 0, "R1 no tick first cycle", int'(tick0), 0);
        rd_chk(1'b0, 32'h0, "R1 prescaler reg reset");
        rd_chk(1'b1, 32'h0, "R1 select reg reset");
        expect_per(0, 0, 2, "R1 default period ch0");
        expect_per(0, 3, 2, "R1 default period ch3");

        // R2: readback and unused-bit masking
        wr(1'b0, 32'hFFFF_FFFF);
        rd_chk(1'b0, 32'h0000_FFFF, "R2 prescaler readback");
        wr(1'b1, 32'hFFFF_FFFF);
        rd_chk(1'b1, 32'h000F_FFFF, "R2 select readback");

        // R3/R4: P0=3, P1=4; codes ch0..ch4 = 0,1,1,2,3
        wr(1'b0, 32'h0000_0403);
        wr(1'b1, 32'h0003_2110);
        rd_chk(1'b0, 32'h0000_0403, "R2 prescaler fields");
        expect_per(0, 0, 8, "R4 div2 group0");
        expect_per(0, 1, 16, "R4 div4 group0");
        expect_per(0, 2, 20, "R3 group1 div4");
        expect_per(0, 3, 40, "R4 div8 group1");
        expect_per(0, 4, 80, "R4 div16 group1");

        // R5: ch1 and ch3 on external clocks
        wr(1'b1, 32'h0003_4140);
        expect_per(0, 1, 12, "R5 ext0 on ch1");
        expect_per(0, 3, 16, "R5 ext1 on ch3");
        expect_per(0, 0, 8, "R3 ch0 unaffected by ch1 ext");

        // R6: deferred prescaler update
        wr(1'b0, 32'h0000_0431);
        expect_per(0, 0, 100, "R3 prescale 49 div2");
        wait_tick(0, 0, t0);
        repeat (5) @(negedge clk);
        wr(1'b0, 32'h0000_0400);
        wait_tick(0, 0, t1);
        check(t1 - t0 == 51, "R6 update at next wrap", t1 - t0, 51);
        expect_per(0, 0, 2, "R6 new prescale active");

        // R7/R8: code 5 on ch0, code 9 on ch2
        wr(1'b1, 32'h0003_2905);
        rd_chk(1'b1, 32'h0003_2905, "R2 reserved code stored");
        expect_per(1, 0, 1, "R7 div1 option");
        count_silent(0, 0, "R8 code 5 without option");
        count_silent(0, 2, "R8 code 9 silent");
        count_silent(1, 2, "R8 code 9 silent with option");
        expect_per(0, 3, 40, "R4 ch3 div8 beside silent ch2");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule